// File: doc/BRIEF.md
# Master Clock Source Switch Sequencer

This block decides which of five clock sources feeds the master clock of a chip: the fast internal RC oscillator, the main crystal oscillator, the PLL, the slow internal RC oscillator or the sub crystal oscillator. Software-style inputs carry a 3-bit source request code and three enable bits, for the main oscillator, the sub oscillator and the PLL. Each oscillator is modelled as a single ready flag. The block answers with the code of the source that currently drives the clock, a busy flag and a boot-wait flag. The clock multiplexer itself lives elsewhere and is steered by the active-source code.

After a hardware reset the block first waits for the fast RC oscillator to report ready, then the slow RC oscillator. Only then does it run, from the fast RC source. A switch to a new source is made only when that source reports ready. Until then the old source stays in use and the busy flag is raised. The PLL can be selected only through a stable main oscillator: the PLL ready flag is honoured only after the main ready flag has been seen while the PLL was being requested. Request codes outside the five defined ones are ignored, and so is a request whose enable bits are missing.

Top module: `mclk_src_seq`

## Requirements
- R1: While reset is held low, and on the first cycle after it, active_src is 000, boot_wait is 1 and switch_busy is 0.
- R2: After reset, boot_wait stays 1 until hrc_ready has been sampled 1 at a clock edge and, at a later edge, lrc_ready has been sampled 1. A lrc_ready seen before hrc_ready does not end the wait. Throughout the wait active_src is 000.
- R3: Source codes on src_sel and active_src are 000 fast RC, 001 main oscillator, 100 slow RC, 010 PLL and 101 sub oscillator. active_src only ever holds one of these five codes.
- R4: Code 001 is a valid request only with main_osc_en = 1. The switch to 001 takes effect at the first clock edge at which main_ready is 1.
- R5: Code 101 is a valid request only with sub_osc_en = 1. The switch to 101 takes effect at the first clock edge at which sub_ready is 1.
- R6: Code 010 is a valid request only with main_osc_en = 1 and pll_en = 1. The PLL becomes active at the first edge with pll_ready = 1 that follows an earlier edge with main_ready = 1, both while the PLL request stays valid. pll_ready on its own never causes the switch.
- R7: Codes 011, 110 and 111, and a valid-looking code whose enable bits are missing, are ignored: active_src keeps its value and switch_busy is 0.
- R8: Outside the boot wait, switch_busy is 1 exactly while a valid request names a source that differs from active_src.
- R9: A hardware reset from any running source returns active_src to 000 and restarts the boot wait of R2.
- R10: A switch to 000 needs hrc_ready = 1 and a switch to 100 needs lrc_ready = 1 at the switching edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| src_sel | input | 3 | Requested source code |
| main_osc_en | input | 1 | Main oscillator enable |
| sub_osc_en | input | 1 | Sub oscillator enable |
| pll_en | input | 1 | PLL enable |
| hrc_ready | input | 1 | Fast RC oscillator stable |
| lrc_ready | input | 1 | Slow RC oscillator stable |
| main_ready | input | 1 | Main oscillator stable |
| sub_ready | input | 1 | Sub oscillator stable |
| pll_ready | input | 1 | PLL locked |
| active_src | output | 3 | Code of the source driving the master clock |
| switch_busy | output | 1 | A valid request is waiting for its source |
| boot_wait | output | 1 | Reset stabilization wait in progress |

## Verification
The hardest case to reach from the ports is the PLL ordering rule. The bench needs a PLL request during which pll_ready is already high while main_ready is still low, and the block must hold the old source there. Then main_ready must rise on its own, and the block must switch only one edge later, once pll_ready is seen. The stimulus reaches this by clearing main_ready after the main oscillator has been selected, asserting pll_ready first, and then swapping the two flags cycle by cycle. It also checks that a reset from a running source restarts the full two-stage boot wait.

// File: rtl/mclk_src_pkg.sv
// Package: shared source codes and widths for the master clock sequencer.
// Assumes: the five codes are fixed by the register layout that software sees.
package mclk_src_pkg;
    localparam int SRC_W = 3;

    typedef enum logic [SRC_W-1:0] {
        SRC_HRC  = 3'b000,
        SRC_MAIN = 3'b001,
        SRC_PLL  = 3'b010,
        SRC_LRC  = 3'b100,
        SRC_SUB  = 3'b101
    } src_e;

    typedef enum logic [1:0] {
        BOOT_HRC  = 2'd0,
        BOOT_LRC  = 2'd1,
        BOOT_DONE = 2'd2
    } boot_e;
endpackage

// File: rtl/mclk_boot_seq.sv
// Module: two-stage stabilization wait after a hardware reset.
// Waits for the fast RC ready flag, then for the slow RC ready flag.
// Assumes: ready flags are already synchronous to clk.
module mclk_boot_seq
    import mclk_src_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hrc_ready,
    input  logic lrc_ready,
    output logic boot_done
);
    boot_e state_q;

    // Advance through the ordered wait stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BOOT_HRC;
        end else begin
            case (state_q)
                BOOT_HRC: if (hrc_ready) state_q <= BOOT_LRC;
                BOOT_LRC: if (lrc_ready) state_q <= BOOT_DONE;
                default:  state_q <= BOOT_DONE;
            endcase
        end
    end

    // Report when the wait has finished.
    always_comb boot_done = (state_q == BOOT_DONE);
endmodule

// File: rtl/mclk_req_decode.sv
// Module: turns the request code and enable bits into a valid request.
// Undefined codes, or codes lacking their enables, give no request.
// Assumes: inputs are stable register values.
module mclk_req_decode
    import mclk_src_pkg::*;
(
    input  logic [SRC_W-1:0] src_sel,
    input  logic             main_osc_en,
    input  logic             sub_osc_en,
    input  logic             pll_en,
    output logic             req_valid,
    output logic [SRC_W-1:0] req_src
);
    // Qualify each code with the enables it depends on.
    always_comb begin
        req_src = src_sel;
        case (src_sel)
            SRC_HRC:  req_valid = 1'b1;
            SRC_MAIN: req_valid = main_osc_en;
            SRC_PLL:  req_valid = main_osc_en && pll_en;
            SRC_LRC:  req_valid = 1'b1;
            SRC_SUB:  req_valid = sub_osc_en;
            default:  req_valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/mclk_pll_gate.sv
// Module: enforces that the PLL is reached only through a stable main
// oscillator. A phase flag is set once main_ready is seen while the PLL is
// requested; only then is pll_ready passed on.
// Assumes: want_pll drops whenever the PLL request goes away.
module mclk_pll_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic boot_done,
    input  logic want_pll,
    input  logic main_ready,
    input  logic pll_ready,
    output logic pll_ok
);
    logic main_seen_q;

    // Remember that the main oscillator stabilized during this PLL request.
    always_ff @(posedge clk) begin
        if (!rst_n)                                    main_seen_q <= 1'b0;
        else if (!want_pll)                            main_seen_q <= 1'b0;
        else if (boot_done && main_ready)              main_seen_q <= 1'b1;
    end

    // Pass the PLL ready flag only after the main stage completed.
    always_comb pll_ok = main_seen_q && pll_ready;
endmodule

// File: rtl/mclk_src_seq.sv
// Module: master clock source switch sequencer (top).
// Holds the active source code, switches to a requested source once it is
// ready, and forces the fast RC source during the reset stabilization wait.
// Assumes: all inputs synchronous to clk; reset is synchronous active-low.
module mclk_src_seq
    import mclk_src_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] src_sel,
    input  logic             main_osc_en,
    input  logic             sub_osc_en,
    input  logic             pll_en,
    input  logic             hrc_ready,
    input  logic             lrc_ready,
    input  logic             main_ready,
    input  logic             sub_ready,
    input  logic             pll_ready,
    output logic [SRC_W-1:0] active_src,
    output logic             switch_busy,
    output logic             boot_wait
);
    logic             boot_done;
    logic             req_valid;
    logic [SRC_W-1:0] req_src;
    logic             want_pll;
    logic             pll_ok;
    logic             tgt_ready;
    logic [SRC_W-1:0] active_q;

    mclk_boot_seq u_boot (
        .clk       (clk),
        .rst_n     (rst_n),
        .hrc_ready (hrc_ready),
        .lrc_ready (lrc_ready),
        .boot_done (boot_done)
    );

    mclk_req_decode u_dec (
        .src_sel     (src_sel),
        .main_osc_en (main_osc_en),
        .sub_osc_en  (sub_osc_en),
        .pll_en      (pll_en),
        .req_valid   (req_valid),
        .req_src     (req_src)
    );

    // Flag a valid PLL request for the ordering gate.
    always_comb want_pll = req_valid && (req_src == SRC_PLL);

    mclk_pll_gate u_pll (
        .clk        (clk),
        .rst_n      (rst_n),
        .boot_done  (boot_done),
        .want_pll   (want_pll),
        .main_ready (main_ready),
        .pll_ready  (pll_ready),
        .pll_ok     (pll_ok)
    );

    // Pick the readiness of the requested source.
    always_comb begin
        case (req_src)
            SRC_HRC:  tgt_ready = hrc_ready;
            SRC_MAIN: tgt_ready = main_ready;
            SRC_PLL:  tgt_ready = pll_ok;
            SRC_LRC:  tgt_ready = lrc_ready;
            SRC_SUB:  tgt_ready = sub_ready;
            default:  tgt_ready = 1'b0;
        endcase
    end

    // A valid request for another source is pending.
    always_comb switch_busy = boot_done && req_valid && (req_src != active_q);

    // Hold or switch the active source.
    always_ff @(posedge clk) begin
        if (!rst_n)                       active_q <= SRC_HRC;
        else if (!boot_done)              active_q <= SRC_HRC;
        else if (switch_busy && tgt_ready) active_q <= req_src;
    end

    // Drive the status outputs.
    always_comb begin
        active_src = active_q;
        boot_wait  = !boot_done;
    end
endmodule

// File: rtl/mclk_src_seq_chk.sv
// Module: property checker for the sequencer, bound to every instance.
module mclk_src_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] src_sel,
    input logic       main_osc_en,
    input logic       sub_osc_en,
    input logic       pll_en,
    input logic       main_ready,
    input logic       sub_ready,
    input logic       pll_ready,
    input logic [2:0] active_src,
    input logic       switch_busy,
    input logic       boot_wait
);
    // R1: first cycle after reset starts from the fast RC source in boot wait.
    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (active_src == 3'b000 && boot_wait && !switch_busy));

    // R2: the boot wait always runs from the fast RC source.
    p_boot_on_hrc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        boot_wait |-> (active_src == 3'b000));

    // R3: only defined codes appear on the active-source output.
    p_legal_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (active_src == 3'b000 || active_src == 3'b001 || active_src == 3'b010 ||
         active_src == 3'b100 || active_src == 3'b101));

    // R4: entering main needs its enable and ready at the switching edge.
    p_main_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (active_src == 3'b001 && $past(active_src) != 3'b001)
        |-> ($past(main_ready) && $past(main_osc_en)));

    // R5: entering sub needs its enable and ready.
    p_sub_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (active_src == 3'b101 && $past(active_src) != 3'b101)
        |-> ($past(sub_ready) && $past(sub_osc_en)));

    // R6: entering PLL needs both enables and the PLL ready flag.
    p_pll_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (active_src == 3'b010 && $past(active_src) != 3'b010)
        |-> ($past(pll_ready) && $past(main_osc_en) && $past(pll_en)));

    // R7: undefined request codes leave the active source alone.
    p_illegal_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!boot_wait && (src_sel == 3'b011 || src_sel == 3'b110 || src_sel == 3'b111))
        |=> $stable(active_src));

    // R8: no busy indication during the boot wait.
    p_no_busy_boot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        boot_wait |-> !switch_busy);
endmodule

bind mclk_src_seq mclk_src_seq_chk u_chk (.*);

// File: tb/tb_mclk_src_seq.sv
// Bench: scoreboard style. The driver applies inputs at the falling edge and
// queues the outputs expected after the next rising edge; the monitor pops
// and compares shortly after each rising edge.
module tb_mclk_src_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] src_sel = 3'b000;
    logic       main_osc_en = 1'b0, sub_osc_en = 1'b0, pll_en = 1'b0;
    logic       hrc_ready = 1'b0, lrc_ready = 1'b0;
    logic       main_ready = 1'b0, sub_ready = 1'b0, pll_ready = 1'b0;
    logic [2:0] active_src;
    logic       switch_busy, boot_wait;

    typedef struct {
        logic [2:0] act;
        logic       busy;
        logic       boot;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    mclk_src_seq dut (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel),
        .main_osc_en(main_osc_en), .sub_osc_en(sub_osc_en), .pll_en(pll_en),
        .hrc_ready(hrc_ready), .lrc_ready(lrc_ready), .main_ready(main_ready),
        .sub_ready(sub_ready), .pll_ready(pll_ready),
        .active_src(active_src), .switch_busy(switch_busy), .boot_wait(boot_wait)
    );

    // Driver: queue the expectation for the coming edge, then step a cycle.
    task automatic step(input logic [2:0] a, input logic b, input logic bt, input string tag);
        exp_t e;
        e.act = a; e.busy = b; e.boot = bt; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    // Monitor: compare outputs just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (active_src !== e.act || switch_busy !== e.busy || boot_wait !== e.boot) begin
                    failures++;
                    $display("FAIL %s: act=%b busy=%b boot=%b expected act=%b busy=%b boot=%b",
                             e.tag, active_src, switch_busy, boot_wait, e.act, e.busy, e.boot);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog: cycles=%0d expected below 5000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        step(3'b000, 1'b0, 1'b1, "R1 reset");
        step(3'b000, 1'b0, 1'b1, "R1 reset held");
        // R2: slow RC ready alone must not finish the wait
        rst_n = 1'b1; lrc_ready = 1'b1;
        step(3'b000, 1'b0, 1'b1, "R2 lrc before hrc");
        hrc_ready = 1'b1; lrc_ready = 1'b0;
        step(3'b000, 1'b0, 1'b1, "R2 hrc stage done");
        lrc_ready = 1'b1;
        step(3'b000, 1'b0, 1'b0, "R2 boot complete");
        // R7: main requested without enable
        src_sel = 3'b001;
        step(3'b000, 1'b0, 1'b0, "R7 main without enable");
        // R4 / R8: main enabled but not ready
        main_osc_en = 1'b1;
        step(3'b000, 1'b1, 1'b0, "R4 main waiting");
        step(3'b000, 1'b1, 1'b0, "R8 busy held");
        main_ready = 1'b1;
        step(3'b001, 1'b0, 1'b0, "R4 main switched");
        // R7: undefined codes
        src_sel = 3'b011; step(3'b001, 1'b0, 1'b0, "R7 code 011");
        src_sel = 3'b110; step(3'b001, 1'b0, 1'b0, "R7 code 110");
        src_sel = 3'b111; step(3'b001, 1'b0, 1'b0, "R7 code 111");
        // R6: PLL ready before main ready must not switch
        src_sel = 3'b010; pll_en = 1'b1; main_ready = 1'b0; pll_ready = 1'b1;
        step(3'b001, 1'b1, 1'b0, "R6 pll before main");
        step(3'b001, 1'b1, 1'b0, "R6 pll before main held");
        main_ready = 1'b1; pll_ready = 1'b0;
        step(3'b001, 1'b1, 1'b0, "R6 main stage seen");
        pll_ready = 1'b1;
        step(3'b010, 1'b0, 1'b0, "R6 pll switched");
        // R5: sub without enable, then waiting, then ready
        src_sel = 3'b101;
        step(3'b010, 1'b0, 1'b0, "R7 sub without enable");
        sub_osc_en = 1'b1;
        step(3'b010, 1'b1, 1'b0, "R5 sub waiting");
        sub_ready = 1'b1;
        step(3'b101, 1'b0, 1'b0, "R5 sub switched");
        // R10: slow RC needs its ready flag
        src_sel = 3'b100; lrc_ready = 1'b0;
        step(3'b101, 1'b1, 1'b0, "R10 lrc waiting");
        lrc_ready = 1'b1;
        step(3'b100, 1'b0, 1'b0, "R10 lrc switched");
        // R10: fast RC
        src_sel = 3'b000;
        step(3'b000, 1'b0, 1'b0, "R10 hrc switched");
        // R3: direct main switch, code 001 on the output
        src_sel = 3'b001;
        step(3'b001, 1'b0, 1'b0, "R3 main code");
        // R9: reset from a running source
        rst_n = 1'b0;
        step(3'b000, 1'b0, 1'b1, "R9 reset from main");
        rst_n = 1'b1; hrc_ready = 1'b0;
        step(3'b000, 1'b0, 1'b1, "R9 boot restarted");
        hrc_ready = 1'b1;
        step(3'b000, 1'b0, 1'b1, "R9 hrc stage");
        step(3'b000, 1'b1, 1'b0, "R9 boot done, main pending");
        step(3'b001, 1'b0, 1'b0, "R9 main after reboot");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule